// File: doc/BRIEF.md
# Memory-Mapped I2C Command Bridge

The bridge is a 32-bit register slave that lets a host processor run single-byte register transactions on a device behind an I2C bus. The host loads a data word into the message buffer and an operation word into the setup register, then sets the start bit in the control register. The bridge decodes the operation, presents one byte transaction to an external line agent through a request/done handshake, and clears the start bit when the agent answers. Read data lands in the low byte of the message buffer, and the outcome is reported in a status register.

Every register value crosses the host bus byte-reversed. Besides plain stores, each register can be reached through two alias windows that turn a store into an atomic AND or OR against the current contents. The host can therefore set or clear single bits without a read-modify-write sequence of its own.

Top module: `i2c_cmd_bridge`

## Requirements
- R1: After a synchronous reset, the message buffer, setup, control and status registers all read zero, `xact_req` is low and `host_rvalid` is low.
- R2: Registers sit at byte offsets 0x008 (message buffer), 0x010 (setup), 0x020 (control) and 0x070 (status) in address bits 11:0. A read returns data one cycle later with `host_rvalid` high for that cycle. Host data is byte-reversed against the internal value: internal bits 7:0 travel on host bits 31:24. Reads ignore address bits 13:12.
- R3: Address bits 13:12 pick the store window: 00 stores the data, 01 ANDs it into the register, 10 ORs it in, and 11 leaves every register unchanged. Unmapped offsets read zero.
- R4: Setup bits 31:28 select the operation: 0x0 read at device address, 0x4 write at device address, 0x1 direct read, 0x6 direct write. Bits 23:16 hold the byte count and must be 0x01. In the at-address modes, the device address is bits 14:8 and the register index is bits 7:0. In the direct modes, the index is bits 15:8 and `xact_dev` is zero. `xact_wr` and `xact_direct` report the mode.
- R5: Setting control bit 1 while idle raises `xact_req` in the next cycle. Control bit 1 reads as 1 until the agent pulses `xact_done`. `xact_req` and its fields hold steady until that pulse and fall in the cycle after it.
- R6: For a write, `xact_wdata` is the low byte of the message buffer at launch. For a successful read, `xact_rdata` replaces bits 7:0 of the message buffer and bits 31:8 are kept.
- R7: When `xact_done` arrives with `xact_nack` high, status bit 1 is set, the start bit clears, and the message buffer is left unchanged.
- R8: Status bit 9 reads 1 while an operation is in progress. A transaction has succeeded when the status bits in mask 0x0000_0A76 are all zero. Launching a new operation clears the error bits of the previous one.
- R9: While an operation is in progress, stores to the control register in any window neither start a second transaction nor clear the start bit. A setup store made then does not alter the transaction in flight.
- R10: An unknown opcode or a byte count other than 1 raises no request. Status bit 2 is set and the start bit clears two cycles after the launching store.
- R11: If a host store to the message buffer lands in the same cycle as a successful read completion, bits 7:0 take the read byte and bits 31:8 take the store result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host store strobe |
| host_rd | input | 1 | Host load strobe |
| host_addr | input | 14 | Byte address; bits 13:12 select the store window |
| host_wdata | input | 32 | Store data, byte-reversed |
| host_rdata | output | 32 | Load data, byte-reversed, registered |
| host_rvalid | output | 1 | Load data valid, one cycle after `host_rd` |
| xact_req | output | 1 | Byte transaction request to the line agent |
| xact_wr | output | 1 | Transaction is a write |
| xact_direct | output | 1 | Transaction uses direct (index-only) addressing |
| xact_dev | output | 7 | 7-bit device address, zero in direct modes |
| xact_index | output | 8 | Register index on the device |
| xact_wdata | output | 8 | Byte to write |
| xact_done | input | 1 | Agent finished the transaction (one-cycle pulse) |
| xact_nack | input | 1 | Agent saw a NACK; valid with `xact_done` |
| xact_rdata | input | 8 | Byte read; valid with `xact_done` |

## Verification
Two functions can update the message buffer in the same clock cycle: a host store through a window, and the agent completing a read. The bench provokes the clash by driving `xact_done` with a read byte and an OR-window store to the buffer on the same clock edge. It then reads the buffer back and compares it with the merge the bench computes: the store result in bits 31:8 and the agent byte in bits 7:0. A second clash, a control store that arrives while a transaction is in flight, is judged by checking that the request fields stay steady, that no second request follows, and that the start bit stays set until `xact_done`.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 32;
  localparam int DEV_W  = 7;
  localparam int BYTE_W = 8;
  localparam int WIN_LSB = 12;
  localparam int OFS_W   = WIN_LSB;

  localparam logic [OFS_W-1:0] OFS_MBUF  = 12'h008;
  localparam logic [OFS_W-1:0] OFS_SETUP = 12'h010;
  localparam logic [OFS_W-1:0] OFS_CTL   = 12'h020;
  localparam logic [OFS_W-1:0] OFS_STAT  = 12'h070;

  localparam int START_BIT = 1;
  localparam int NACK_BIT  = 1;
  localparam int BADOP_BIT = 2;
  localparam int BUSY_BIT  = 9;

  localparam logic [3:0] OPC_RD_AT  = 4'h0;
  localparam logic [3:0] OPC_RD_DIR = 4'h1;
  localparam logic [3:0] OPC_WR_AT  = 4'h4;
  localparam logic [3:0] OPC_WR_DIR = 4'h6;

  typedef enum logic [1:0] {
    WIN_PLAIN = 2'b00,
    WIN_AND   = 2'b01,
    WIN_OR    = 2'b10,
    WIN_VOID  = 2'b11
  } win_e;

  typedef struct packed {
    logic              ok;
    logic              wr;
    logic              direct;
    logic [DEV_W-1:0]  dev;
    logic [BYTE_W-1:0] index;
  } cmd_t;

  function automatic logic [DATA_W-1:0] swap32(input logic [DATA_W-1:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [DATA_W-1:0] merge(input win_e w,
                                              input logic [DATA_W-1:0] old_v,
                                              input logic [DATA_W-1:0] d);
    case (w)
      WIN_PLAIN: return d;
      WIN_AND:   return old_v & d;
      WIN_OR:    return old_v | d;
      default:   return old_v;
    endcase
  endfunction

  function automatic cmd_t decode_setup(input logic [DATA_W-1:0] s);
    cmd_t c;
    c.ok     = (s[23:16] == 8'h01);
    c.wr     = 1'b0;
    c.direct = 1'b0;
    case (s[31:28])
      OPC_RD_AT:  begin c.wr = 1'b0; c.direct = 1'b0; end
      OPC_WR_AT:  begin c.wr = 1'b1; c.direct = 1'b0; end
      OPC_RD_DIR: begin c.wr = 1'b0; c.direct = 1'b1; end
      OPC_WR_DIR: begin c.wr = 1'b1; c.direct = 1'b1; end
      default:    c.ok = 1'b0;
    endcase
    c.dev   = c.direct ? '0 : s[14:8];
    c.index = c.direct ? s[15:8] : s[7:0];
    return c;
  endfunction
endpackage

// File: rtl/i2cb_regs.sv
module i2cb_regs
  import i2cb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              ld_rbyte,
  input  logic [BYTE_W-1:0] rbyte,
  input  logic              st_nack,
  input  logic              st_bad,
  output logic [DATA_W-1:0] mbuf,
  output logic [DATA_W-1:0] setup,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              launch
);
  win_e              win;
  logic [OFS_W-1:0]  ofs;
  logic              wr_ok;
  logic [DATA_W-1:0] ctl_now, ctl_new, stat_now, mbuf_nxt;

  assign win   = win_e'(host_addr[WIN_LSB+1:WIN_LSB]);
  assign ofs   = host_addr[OFS_W-1:0];
  assign wr_ok = host_wr && (win != WIN_VOID);

  always_comb begin
    ctl_now            = '0;
    ctl_now[START_BIT] = busy;
    ctl_new            = merge(win, ctl_now, wdata);
    stat_now            = '0;
    stat_now[BUSY_BIT]  = busy;
    stat_now[BADOP_BIT] = st_bad;
    stat_now[NACK_BIT]  = st_nack;
  end

  // a start only counts from idle; the store result decides
  assign launch = wr_ok && (ofs == OFS_CTL) && ctl_new[START_BIT] && !busy;

  always_comb begin
    mbuf_nxt = mbuf;
    if (wr_ok && ofs == OFS_MBUF) mbuf_nxt = merge(win, mbuf, wdata);
    if (ld_rbyte) mbuf_nxt[BYTE_W-1:0] = rbyte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mbuf   <= '0;
      setup  <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      mbuf   <= mbuf_nxt;
      rvalid <= host_rd;
      if (wr_ok && ofs == OFS_SETUP) setup <= merge(win, setup, wdata);
      if (host_rd) begin
        case (ofs)
          OFS_MBUF:  rdata <= mbuf;
          OFS_SETUP: rdata <= setup;
          OFS_CTL:   rdata <= ctl_now;
          OFS_STAT:  rdata <= stat_now;
          default:   rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
  import i2cb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [DATA_W-1:0] setup,
  input  logic [BYTE_W-1:0] mbuf_lo,
  input  logic              xact_done,
  input  logic              xact_nack,
  input  logic [BYTE_W-1:0] xact_rdata,
  output logic              xact_req,
  output logic              xact_wr,
  output logic              xact_direct,
  output logic [DEV_W-1:0]  xact_dev,
  output logic [BYTE_W-1:0] xact_index,
  output logic [BYTE_W-1:0] xact_wdata,
  output logic              busy,
  output logic              ld_rbyte,
  output logic [BYTE_W-1:0] rbyte,
  output logic              st_nack,
  output logic              st_bad
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_BAD} state_e;
  state_e state;
  cmd_t   cmd;

  assign cmd      = decode_setup(setup);
  assign busy     = (state != S_IDLE);
  assign xact_req = (state == S_REQ);
  assign ld_rbyte = (state == S_REQ) && xact_done && !xact_nack && !xact_wr;
  assign rbyte    = xact_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      xact_wr     <= 1'b0;
      xact_direct <= 1'b0;
      xact_dev    <= '0;
      xact_index  <= '0;
      xact_wdata  <= '0;
      st_nack     <= 1'b0;
      st_bad      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (launch) begin
          st_nack <= 1'b0;
          if (cmd.ok) begin
            state       <= S_REQ;
            st_bad      <= 1'b0;
            xact_wr     <= cmd.wr;
            xact_direct <= cmd.direct;
            xact_dev    <= cmd.dev;
            xact_index  <= cmd.index;
            xact_wdata  <= mbuf_lo;
          end else begin
            state  <= S_BAD;
            st_bad <= 1'b1;
          end
        end
        S_REQ: if (xact_done) begin
          state   <= S_IDLE;
          st_nack <= xact_nack;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_bridge.sv
module i2c_cmd_bridge
  import i2cb_pkg::*;
#(
  parameter bit BYTE_SWAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              xact_req,
  output logic              xact_wr,
  output logic              xact_direct,
  output logic [DEV_W-1:0]  xact_dev,
  output logic [BYTE_W-1:0] xact_index,
  output logic [BYTE_W-1:0] xact_wdata,
  input  logic              xact_done,
  input  logic              xact_nack,
  input  logic [BYTE_W-1:0] xact_rdata
);
  logic [DATA_W-1:0] wdata_int, rdata_int, mbuf_w, setup_w;
  logic              busy_w, launch_w, ld_rbyte_w, st_nack_w, st_bad_w;
  logic [BYTE_W-1:0] rbyte_w;

  generate
    if (BYTE_SWAP) begin : g_swap
      assign wdata_int  = swap32(host_wdata);
      assign host_rdata = swap32(rdata_int);
    end else begin : g_flat
      assign wdata_int  = host_wdata;
      assign host_rdata = rdata_int;
    end
  endgenerate

  i2cb_regs u_regs (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .wdata(wdata_int), .busy(busy_w),
    .ld_rbyte(ld_rbyte_w), .rbyte(rbyte_w), .st_nack(st_nack_w),
    .st_bad(st_bad_w), .mbuf(mbuf_w), .setup(setup_w),
    .rdata(rdata_int), .rvalid(host_rvalid), .launch(launch_w)
  );

  i2cb_seq u_seq (
    .clk(clk), .rst(rst), .launch(launch_w), .setup(setup_w),
    .mbuf_lo(mbuf_w[BYTE_W-1:0]), .xact_done(xact_done),
    .xact_nack(xact_nack), .xact_rdata(xact_rdata),
    .xact_req(xact_req), .xact_wr(xact_wr), .xact_direct(xact_direct),
    .xact_dev(xact_dev), .xact_index(xact_index), .xact_wdata(xact_wdata),
    .busy(busy_w), .ld_rbyte(ld_rbyte_w), .rbyte(rbyte_w),
    .st_nack(st_nack_w), .st_bad(st_bad_w)
  );
endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker
  import i2cb_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              host_rd,
  input logic              host_rvalid,
  input logic              xact_req,
  input logic              xact_wr,
  input logic [DEV_W-1:0]  xact_dev,
  input logic [BYTE_W-1:0] xact_index,
  input logic [BYTE_W-1:0] xact_wdata,
  input logic              xact_done,
  input logic              xact_nack,
  input logic              launch,
  input logic              busy,
  input logic              st_nack
);
  assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid);
  assert_rvalid_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> !host_rvalid);
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (xact_req && !xact_done) |=> (xact_req && $stable(xact_index) &&
      $stable(xact_dev) && $stable(xact_wdata) && $stable(xact_wr)));
  assert_done_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (xact_req && xact_done) |=> (!xact_req && !busy));
  assert_req_in_busy_R5: assert property (@(posedge clk) disable iff (rst)
    xact_req |-> busy);
  assert_nack_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (xact_req && xact_done && xact_nack) |=> st_nack);
  assert_ok_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (xact_req && xact_done && !xact_nack) |=> !st_nack);
  assert_launch_busy_R9: assert property (@(posedge clk) disable iff (rst)
    launch |=> busy);
endmodule

bind i2c_cmd_bridge i2cb_checker u_chk (
  .clk(clk), .rst(rst), .host_rd(host_rd), .host_rvalid(host_rvalid),
  .xact_req(xact_req), .xact_wr(xact_wr), .xact_dev(xact_dev),
  .xact_index(xact_index), .xact_wdata(xact_wdata), .xact_done(xact_done),
  .xact_nack(xact_nack), .launch(launch_w), .busy(busy_w),
  .st_nack(st_nack_w)
);

// File: tb/i2c_cmd_bridge_tb_top.sv
`timescale 1ns/1ps
module i2c_cmd_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [13:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        xact_req, xact_wr, xact_direct;
  logic [6:0]  xact_dev;
  logic [7:0]  xact_index, xact_wdata;
  logic        xact_done = 1'b0, xact_nack = 1'b0;
  logic [7:0]  xact_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  localparam logic [13:0] A_MBUF = 14'h0008, A_SETUP = 14'h0010;
  localparam logic [13:0] A_CTL  = 14'h0020, A_STAT  = 14'h0070;
  localparam logic [13:0] W_AND = 14'h1000, W_OR = 14'h2000, W_VOID = 14'h3000;

  always #4 clk = ~clk;

  i2c_cmd_bridge dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .xact_req(xact_req), .xact_wr(xact_wr),
    .xact_direct(xact_direct), .xact_dev(xact_dev), .xact_index(xact_index),
    .xact_wdata(xact_wdata), .xact_done(xact_done), .xact_nack(xact_nack),
    .xact_rdata(xact_rdata)
  );

  function automatic logic [31:0] rev(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [13:0] a, input logic [31:0] v);
    host_wr = 1'b1; host_addr = a; host_wdata = rev(v);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [13:0] a, output logic [31:0] v);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    v = rev(host_rdata);
    expect32("R2 rvalid", {31'b0, host_rvalid}, 32'd1);
    host_rd = 1'b0;
  endtask

  task automatic rd_expect(input string tag, input logic [13:0] a, input logic [31:0] exp);
    logic [31:0] v;
    hrd(a, v);
    expect32(tag, v, exp);
  endtask

  task automatic do_op(input logic [31:0] su, input logic [31:0] mb,
                       input int dly, input bit nk, input logic [7:0] rb);
    logic [3:0] opc;
    bit ok, wr, dir;
    logic [6:0] dev;
    logic [7:0] idx;
    opc = su[31:28];
    ok  = ((opc == 4'h0) || (opc == 4'h1) || (opc == 4'h4) || (opc == 4'h6)) &&
          (su[23:16] == 8'h01);
    wr  = (opc == 4'h4) || (opc == 4'h6);
    dir = (opc == 4'h1) || (opc == 4'h6);
    dev = dir ? 7'h0 : su[14:8];
    idx = dir ? su[15:8] : su[7:0];
    hwr(A_MBUF, mb);
    hwr(A_SETUP, su);
    hwr(A_CTL, 32'h2);
    if (!ok) begin
      expect32("R10 no request", {31'b0, xact_req}, 32'd0);
      @(negedge clk);
      rd_expect("R10 status bad op", A_STAT, 32'h4);
      rd_expect("R10 start cleared", A_CTL, 32'h0);
      return;
    end
    expect32("R5 request raised", {31'b0, xact_req}, 32'd1);
    expect32("R4 fields", {xact_wr, xact_direct, xact_dev, xact_index},
             {15'b0, wr, dir, dev, idx});
    if (wr) expect32("R6 write byte", {24'b0, xact_wdata}, {24'b0, mb[7:0]});
    rd_expect("R5 start reads 1", A_CTL, 32'h2);
    rd_expect("R8 busy bit", A_STAT, 32'h200);
    repeat (dly) @(negedge clk);
    xact_done = 1'b1; xact_nack = nk; xact_rdata = rb;
    @(negedge clk);
    xact_done = 1'b0; xact_nack = 1'b0;
    expect32("R5 request dropped", {31'b0, xact_req}, 32'd0);
    rd_expect("R5 start cleared", A_CTL, 32'h0);
    rd_expect(nk ? "R7 nack status" : "R8 clean status", A_STAT, nk ? 32'h2 : 32'h0);
    rd_expect(nk ? "R7 buffer kept" : "R6 buffer", A_MBUF,
              (!wr && !nk) ? {mb[31:8], rb} : mb);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] exp_mb;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    expect32("R1 req low", {31'b0, xact_req}, 32'd0);
    expect32("R1 rvalid low", {31'b0, host_rvalid}, 32'd0);
    rd_expect("R1 mbuf", A_MBUF, 0);
    rd_expect("R1 setup", A_SETUP, 0);
    rd_expect("R1 ctl", A_CTL, 0);
    rd_expect("R1 status", A_STAT, 0);

    // R2 byte order at the host bus
    host_wr = 1'b1; host_addr = A_MBUF; host_wdata = 32'hA1B2C3D4;
    @(negedge clk); host_wr = 1'b0;
    host_rd = 1'b1; host_addr = A_MBUF;
    @(negedge clk); host_rd = 1'b0;
    expect32("R2 raw readback", host_rdata, 32'hA1B2C3D4);
    hwr(A_SETUP, 32'h4001_2A5C);
    hwr(A_CTL, 32'h2);
    expect32("R2 low byte from host msb", {24'b0, xact_wdata}, 32'hA1);
    xact_done = 1'b1; @(negedge clk); xact_done = 1'b0;

    // R3 windows
    hwr(A_MBUF, 32'hFFFF_0000);
    hwr(A_MBUF | W_AND, 32'h0F0F_0F0F);
    rd_expect("R3 and window", A_MBUF, 32'h0F0F_0000);
    hwr(A_MBUF | W_OR, 32'h0000_00F0);
    rd_expect("R3 or window", A_MBUF, 32'h0F0F_00F0);
    hwr(A_MBUF | W_VOID, 32'h1234_5678);
    rd_expect("R3 void window", A_MBUF, 32'h0F0F_00F0);
    hwr(A_SETUP | W_OR, 32'h0000_8000);
    rd_expect("R3 or setup", A_SETUP, 32'h4001_AA5C);
    rd_expect("R3 unmapped", 14'h000C, 32'h0);
    hwr(A_CTL | W_AND, 32'hFFFF_FFFF);
    expect32("R3 and cannot start", {31'b0, xact_req}, 32'd0);

    // R4..R8 directed modes
    do_op(32'h4001_3A10, 32'h0000_0055, 1, 1'b0, 8'h00); // write at addr
    do_op(32'h0001_5011, 32'hDEAD_BE00, 0, 1'b0, 8'h7E); // read at addr
    do_op(32'h1001_2200, 32'h1111_1111, 3, 1'b0, 8'h99); // direct read
    do_op(32'h6001_4400, 32'h0000_00C0, 2, 1'b0, 8'h00); // direct write
    do_op(32'h0001_2233, 32'hCAFE_F00D, 1, 1'b1, 8'h44); // R7 nacked read
    do_op(32'h0001_2233, 32'h0000_0001, 0, 1'b0, 8'h45); // R8 error cleared
    do_op(32'hB001_0000, 32'h0, 0, 1'b0, 8'h00);         // R10 bad opcode
    do_op(32'h4002_0000, 32'h0, 0, 1'b0, 8'h00);         // R10 bad count

    // R9 stores to control during a transaction
    hwr(A_MBUF, 32'h0000_0011);
    hwr(A_SETUP, 32'h4001_0506);
    hwr(A_CTL, 32'h2);
    hwr(A_CTL, 32'h0);
    hwr(A_CTL | W_AND, 32'h0);
    hwr(A_SETUP, 32'h0001_7F7F);
    hwr(A_CTL | W_OR, 32'h2);
    expect32("R9 fields held", {xact_req, xact_wr, xact_dev, xact_index},
             {16'b0, 1'b1, 1'b1, 7'h05, 8'h06});
    rd_expect("R9 start kept", A_CTL, 32'h2);
    xact_done = 1'b1; @(negedge clk); xact_done = 1'b0;
    repeat (3) @(negedge clk);
    expect32("R9 no second request", {31'b0, xact_req}, 32'd0);
    rd_expect("R9 setup updated", A_SETUP, 32'h0001_7F7F);

    // R11 store to buffer on the completion cycle
    hwr(A_MBUF, 32'h1234_5678);
    hwr(A_SETUP, 32'h0001_0102);
    hwr(A_CTL, 32'h2);
    xact_done = 1'b1; xact_rdata = 8'hC3;
    host_wr = 1'b1; host_addr = A_MBUF | W_OR; host_wdata = rev(32'h00F0_F000);
    @(negedge clk);
    xact_done = 1'b0; host_wr = 1'b0;
    exp_mb = 32'h1234_5678 | 32'h00F0_F000;
    rd_expect("R11 merged buffer", A_MBUF, {exp_mb[31:8], 8'hC3});

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [3:0] opc;
      logic [7:0] cnt;
      case ($urandom % 5)
        0: opc = 4'h0;
        1: opc = 4'h1;
        2: opc = 4'h4;
        3: opc = 4'h6;
        default: opc = 4'hB;
      endcase
      cnt = (($urandom % 8) == 0) ? 8'h03 : 8'h01;
      do_op({opc, 4'h0, cnt, 1'b0, 7'($urandom), 8'($urandom)}, $urandom,
            int'($urandom % 4), (($urandom % 4) == 0), 8'($urandom));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule